// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the pins of a serial flash style slave and its transaction logic. It watches the chip-select, serial clock and pause request lines, all three sampled by a fast system clock. It decides when a transaction is frozen and when it resumes. While the pause is in force, the block suppresses the serial clock strobes that drive the shifters. It keeps a bit counter from advancing and withdraws the output enable of the serial data output. The counter and shift state are therefore intact when the pause is lifted.

The pause does not take effect the moment the request line moves. Both entry and exit are aligned to a phase in which the sampled serial clock is low. A request edge that arrives while the clock is high is deferred until the clock next falls. If chip-select is released while the transaction is paused, the block issues a one-cycle transaction reset and clears the counter. It then keeps the shifters frozen until the pause request is withdrawn and chip-select is low again.

The three pins pass through a `SYNC_STAGES`-deep synchroniser; 0 stages selects a bypass for pins that are already synchronous. Serial clock edges are found by comparing the synchronised sample with the previous one. The pin-to-`hold_active` latency is `SYNC_STAGES`+1 system clock cycles. The pause pin and the serial clock pin share the same delay, so their relative timing at the pins is preserved.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, `hold_active`, `xact_rst`, `so_oe`, `shift_rise_en` and `shift_fall_en` are 0 and `bit_cnt` is 0.
- R2: While the sampled chip-select is high (inactive), a low pause request never starts a pause.
- R3: With chip-select low, a pause request that goes low while the serial clock is low raises `hold_active` `SYNC_STAGES`+1 cycles after the pin change.
- R4: A pause request that goes low while the serial clock is high starts the pause only once the serial clock is sampled low; a serial clock rise that precedes the request at the pins is still counted.
- R5: A pause ends only when the request is high and the serial clock is sampled low. A release while the clock is high is deferred to the next low phase.
- R6: While `hold_active` is 1, serial clock edges produce no shift strobes and leave `bit_cnt` unchanged, and counting resumes from the held value after the pause ends.
- R7: `so_oe` is 1 only when `so_drive` is 1, chip-select is low and no pause is active.
- R8: Chip-select going high during a pause produces exactly one `xact_rst` pulse and clears `bit_cnt`. `hold_active` then stays 1 until the request is high, chip-select is low and the serial clock is low.
- R9: `bit_cnt` counts qualified serial clock rising edges modulo 2^`CNT_W` and is held at 0 while chip-select is high.
- R10: A pause request pulse that starts and ends within one high phase of the serial clock causes no pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Chip-select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| hold_n_pin | input | 1 | Pause request pin, active low |
| so_drive | input | 1 | Transaction logic wants to drive the serial data output |
| hold_active | output | 1 | Transaction frozen; shifters must not advance |
| so_oe | output | 1 | Output enable for the serial data output driver |
| xact_rst | output | 1 | One-cycle pulse: transaction aborted during a pause |
| shift_rise_en | output | 1 | Qualified serial clock rising edge strobe |
| shift_fall_en | output | 1 | Qualified serial clock falling edge strobe |
| bit_cnt | output | CNT_W | Bit position inside the current transaction |

## Verification
The assertions check on every cycle the following. `hold_active` rises only after a cycle with chip-select low, the request low and the clock low. It falls only after a cycle with the request high, chip-select low and the clock low. The counter is frozen during a pause and cleared while chip-select is high. A transaction reset is a single cycle caused by a chip-select rise inside a pause. The bench scenarios show what no single-cycle property can. It sweeps the position of the request edge across a whole serial clock period and checks whether the adjacent clock rise was counted. It also checks the exact pin-to-pause latency, the deferral of entry and exit through a high clock phase, and a short request pulse swallowed inside a high phase. Finally, it checks the resume sequence after an aborted transaction and the counter wrap.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

   // Positions of the pins inside the synchroniser vector
   localparam int PIN_CS   = 0;
   localparam int PIN_SCK  = 1;
   localparam int PIN_HOLD = 2;
   localparam int NUM_PINS = 3;

   // Reset levels: chip-select inactive, clock low, no pause request
   localparam logic [NUM_PINS-1:0] PIN_RST_LEVEL = 3'b101;

   typedef enum logic [2:0] {
      HS_RUN        = 3'd0,  // transaction advancing
      HS_ENTER_WAIT = 3'd1,  // request low, clock high: waiting for low phase
      HS_HELD       = 3'd2,  // transaction frozen
      HS_EXIT_WAIT  = 3'd3,  // request high, clock high: waiting for low phase
      HS_ABORTED    = 3'd4   // chip-select rose while frozen
   } hold_state_t;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
   parameter int                WIDTH   = 3,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("spi_hold_sync: WIDTH must be at least 1");
   end
   if (STAGES == 1 || STAGES < 0) begin : g_bad_stages
      $error("spi_hold_sync: STAGES must be 0 (bypass) or at least 2");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end

      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
   parameter int               WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cur,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);

   if (WIDTH < 1) begin : g_bad_width
      $error("spi_hold_edge: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= cur;
   end

   assign rise = cur & ~prev_q;
   assign fall = ~cur & prev_q;

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
   import spi_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic sck_s,
   input  logic hold_n_s,
   output logic hold_active,
   output logic xact_rst
);

   hold_state_t state_q, state_d;
   logic        abort_d;
   logic        xrst_q;

   always_comb begin
      state_d = state_q;
      abort_d = 1'b0;
      unique case (state_q)
         HS_RUN: begin
            if (!cs_n_s && !hold_n_s)
               state_d = sck_s ? HS_ENTER_WAIT : HS_HELD;
         end
         HS_ENTER_WAIT: begin
            if (cs_n_s)      state_d = HS_RUN;
            else if (!sck_s) state_d = hold_n_s ? HS_RUN : HS_HELD;
         end
         HS_HELD: begin
            if (cs_n_s) begin
               state_d = HS_ABORTED;
               abort_d = 1'b1;
            end else if (hold_n_s) begin
               state_d = sck_s ? HS_EXIT_WAIT : HS_RUN;
            end
         end
         HS_EXIT_WAIT: begin
            if (cs_n_s) begin
               state_d = HS_ABORTED;
               abort_d = 1'b1;
            end else if (!sck_s) begin
               state_d = hold_n_s ? HS_RUN : HS_HELD;
            end
         end
         HS_ABORTED: begin
            if (!cs_n_s && hold_n_s && !sck_s) state_d = HS_RUN;
         end
         default: state_d = HS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= HS_RUN;
         xrst_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         xrst_q  <= abort_d;
      end
   end

   assign hold_active = (state_q == HS_HELD) || (state_q == HS_EXIT_WAIT) ||
                        (state_q == HS_ABORTED);
   assign xact_rst    = xrst_q;

   // R2: an inactive chip-select never lets a pause begin
   p_no_entry_cs_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_s && !hold_active) |=> !hold_active);

   // R3, R4: entry only from a cycle with request low and clock low
   p_entry_sck_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_active) |-> $past(!sck_s && !hold_n_s && !cs_n_s));

   // R5, R8: exit only from a cycle with request high, clock low, chip-select low
   p_exit_sck_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_active) |-> $past(!sck_s && hold_n_s && !cs_n_s));

   // R8: the transaction reset is caused by a chip-select rise during a pause
   p_xrst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xact_rst |-> ($past(hold_active && cs_n_s) && hold_active));

   // R8: the transaction reset lasts a single cycle
   p_xrst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xact_rst |=> !xact_rst);

endmodule

// File: rtl/spi_hold_bitcnt.sv
module spi_hold_bitcnt #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_s,
   input  logic             hold_active,
   input  logic             xact_rst,
   input  logic             sck_rise,
   input  logic             sck_fall,
   output logic             shift_rise_en,
   output logic             shift_fall_en,
   output logic [CNT_W-1:0] bit_cnt
);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("spi_hold_bitcnt: CNT_W must be 1..32");
   end

   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             advance_ok;
   logic [CNT_W-1:0] cnt_q;

   assign advance_ok    = !cs_n_s && !hold_active;
   assign shift_rise_en = sck_rise && advance_ok;
   assign shift_fall_en = sck_fall && advance_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (cs_n_s || xact_rst) cnt_q <= '0;
      else if (shift_rise_en)      cnt_q <= cnt_q + CNT_ONE;
   end

   assign bit_cnt = cnt_q;

   // R6: a frozen transaction keeps its bit position
   p_cnt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_active && !cs_n_s && !xact_rst) |=> $stable(bit_cnt));

   // R9: chip-select high clears the position
   p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (bit_cnt == '0));

   // R8: transaction reset clears the position
   p_cnt_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      xact_rst |=> (bit_cnt == '0));

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
   import spi_hold_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n_pin,
   input  logic             sck_pin,
   input  logic             hold_n_pin,
   input  logic             so_drive,
   output logic             hold_active,
   output logic             so_oe,
   output logic             xact_rst,
   output logic             shift_rise_en,
   output logic             shift_fall_en,
   output logic [CNT_W-1:0] bit_cnt
);

   logic [NUM_PINS-1:0] pins_raw;
   logic [NUM_PINS-1:0] pins_s;
   logic                cs_n_s, sck_s, hold_n_s;
   logic                sck_rise, sck_fall;
   logic                hold_q;
   logic                xrst_q;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_CS]   = cs_n_pin;
      pins_raw[PIN_SCK]  = sck_pin;
      pins_raw[PIN_HOLD] = hold_n_pin;
   end

   spi_hold_sync #(
      .WIDTH   (NUM_PINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST_LEVEL)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   assign cs_n_s   = pins_s[PIN_CS];
   assign sck_s    = pins_s[PIN_SCK];
   assign hold_n_s = pins_s[PIN_HOLD];

   spi_hold_edge #(
      .WIDTH   (1),
      .RST_VAL (PIN_RST_LEVEL[PIN_SCK])
   ) u_sck_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (sck_s),
      .rise  (sck_rise),
      .fall  (sck_fall)
   );

   spi_hold_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_s      (cs_n_s),
      .sck_s       (sck_s),
      .hold_n_s    (hold_n_s),
      .hold_active (hold_q),
      .xact_rst    (xrst_q)
   );

   spi_hold_bitcnt #(
      .CNT_W (CNT_W)
   ) u_bitcnt (
      .clk           (clk),
      .rst_n         (rst_n),
      .cs_n_s        (cs_n_s),
      .hold_active   (hold_q),
      .xact_rst      (xrst_q),
      .sck_rise      (sck_rise),
      .sck_fall      (sck_fall),
      .shift_rise_en (shift_rise_en),
      .shift_fall_en (shift_fall_en),
      .bit_cnt       (bit_cnt)
   );

   assign hold_active = hold_q;
   assign xact_rst    = xrst_q;
   assign so_oe       = so_drive && !cs_n_s && !hold_q;

   // R7: the output driver is released for the whole pause
   p_so_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hold_q) && hold_q) |-> !so_oe);

endmodule

// File: tb/spi_hold_ctrl_tb.sv
module spi_hold_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int STAGES     = 2;
   localparam int CW         = 6;
   localparam int LAT        = STAGES + 1;
   localparam int HALF       = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n_pin = 1'b1;
   logic          sck_pin = 1'b0;
   logic          hold_n_pin = 1'b1;
   logic          so_drive = 1'b1;
   logic          hold_active, so_oe, xact_rst, shift_rise_en, shift_fall_en;
   logic [CW-1:0] bit_cnt;

   int n_checks = 0;
   int n_errors = 0;
   int exp_cnt  = 0;
   int xrst_seen = 0;
   int held_strobes = 0;
   logic mon_hold = 1'b0;
   logic hold_seen = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_hold_ctrl #(.SYNC_STAGES(STAGES), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin),
      .hold_n_pin(hold_n_pin), .so_drive(so_drive), .hold_active(hold_active),
      .so_oe(so_oe), .xact_rst(xact_rst), .shift_rise_en(shift_rise_en),
      .shift_fall_en(shift_fall_en), .bit_cnt(bit_cnt)
   );

   always @(negedge clk) begin
      if (rst_n && xact_rst) xrst_seen++;
      if (rst_n && hold_active && (shift_rise_en || shift_fall_en)) held_strobes++;
      if (mon_hold && hold_active) hold_seen = 1'b1;
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic sck_pulse(input bit counted);
      sck_pin = 1'b1; step(HALF);
      sck_pin = 1'b0; step(HALF);
      if (counted) exp_cnt = (exp_cnt + 1) % (1 << CW);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1: reset state
      check("R1 hold_active", hold_active, 0);
      check("R1 xact_rst", xact_rst, 0);
      check("R1 so_oe", so_oe, 0);
      check("R1 bit_cnt", bit_cnt, 0);
      check("R1 strobes", shift_rise_en | shift_fall_en, 0);

      // R9, R7: plain counting with output enabled
      cs_n_pin = 1'b0; step(LAT + 1);
      for (int i = 0; i < 5; i++) sck_pulse(1);
      check("R9 count 5", bit_cnt, exp_cnt);
      check("R7 oe active", so_oe, 1);

      // R3: exact entry latency with clock low
      hold_n_pin = 1'b0;
      step(LAT - 1);
      check("R3 not yet held", hold_active, 0);
      step(1);
      check("R3 held after latency", hold_active, 1);
      check("R7 oe released", so_oe, 0);
      // R6: clock edges during pause are ignored
      held_strobes = 0;
      for (int i = 0; i < 4; i++) sck_pulse(0);
      check("R6 frozen count", bit_cnt, exp_cnt);
      check("R6 no strobes", held_strobes, 0);
      // R5: exit with clock low
      hold_n_pin = 1'b1;
      step(LAT - 1);
      check("R5 still held", hold_active, 1);
      step(1);
      check("R5 released", hold_active, 0);
      for (int i = 0; i < 3; i++) sck_pulse(1);
      check("R6 resumed count", bit_cnt, exp_cnt);

      // R4: entry deferred through a high clock phase
      sck_pin = 1'b1; step(HALF);
      exp_cnt++;
      hold_n_pin = 1'b0; step(2 * HALF);
      check("R4 deferred entry", hold_active, 0);
      sck_pin = 1'b0; step(LAT);
      check("R4 entry at low phase", hold_active, 1);
      check("R4 prior rise counted", bit_cnt, exp_cnt);
      // R5: exit deferred through a high clock phase
      sck_pin = 1'b1; step(HALF);
      hold_n_pin = 1'b1; step(2 * HALF);
      check("R5 deferred exit", hold_active, 1);
      sck_pin = 1'b0; step(LAT);
      check("R5 exit at low phase", hold_active, 0);
      check("R6 count after deferred exit", bit_cnt, exp_cnt);

      // R10: request pulse contained in one high phase
      hold_seen = 1'b0; mon_hold = 1'b1;
      sck_pin = 1'b1; step(HALF);
      exp_cnt++;
      hold_n_pin = 1'b0; step(HALF);
      hold_n_pin = 1'b1; step(HALF);
      sck_pin = 1'b0; step(2 * HALF);
      mon_hold = 1'b0;
      check("R10 no pause", hold_seen, 0);
      check("R10 count", bit_cnt, exp_cnt);

      // R2, R9: chip-select high clears and blocks pause
      cs_n_pin = 1'b1; step(2 * HALF);
      exp_cnt = 0;
      check("R9 cleared by chip-select", bit_cnt, 0);
      check("R7 oe off with chip-select high", so_oe, 0);
      hold_n_pin = 1'b0; step(2 * HALF);
      check("R2 no pause while deselected", hold_active, 0);
      hold_n_pin = 1'b1; step(LAT + 1);

      // R8: chip-select rise during pause
      cs_n_pin = 1'b0; step(LAT + 1);
      for (int i = 0; i < 3; i++) sck_pulse(1);
      hold_n_pin = 1'b0; step(LAT + 1);
      check("R8 paused", hold_active, 1);
      xrst_seen = 0;
      cs_n_pin = 1'b1; step(2 * HALF);
      check("R8 single reset pulse", xrst_seen, 1);
      check("R8 count cleared", bit_cnt, 0);
      check("R8 still frozen", hold_active, 1);
      cs_n_pin = 1'b0; step(2 * HALF);
      check("R8 frozen with request low", hold_active, 1);
      hold_n_pin = 1'b1; step(LAT);
      check("R8 resumed", hold_active, 0);
      check("R8 no extra pulse", xrst_seen, 1);
      exp_cnt = 0;

      // R3, R4, R6: sweep request fall across one clock period
      for (int off = 0; off < 2 * HALF; off++) begin
         for (int c = 0; c < 3 * HALF; c++) begin
            if (c == off)      hold_n_pin = 1'b0;
            if (c == HALF)     sck_pin = 1'b1;
            if (c == 2 * HALF) sck_pin = 1'b0;
            step(1);
         end
         if (off >= HALF) exp_cnt++;
         step(LAT + 1);
         check($sformatf("R4 sweep off=%0d held", off), hold_active, 1);
         check($sformatf("R6 sweep off=%0d count", off), bit_cnt, exp_cnt % (1 << CW));
         hold_n_pin = 1'b1; step(LAT + 1);
         check($sformatf("R5 sweep off=%0d released", off), hold_active, 0);
      end

      // R9: wrap of the bit counter
      for (int i = 0; i < 70; i++) sck_pulse(1);
      exp_cnt = exp_cnt % (1 << CW);
      check("R9 wrap", bit_cnt, exp_cnt);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule